// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external controller read and write an 8-bit register space with 13-bit addresses over a four-wire serial link. The link has an active-low select, a serial clock, data in and data out. The controller sends one fixed 24-bit command per select window, most-significant bit first. The first bit gives the direction: 0 writes and 1 reads. The next two bits form a multi-byte field that must be zero. A 13-bit address follows, and the last eight bits are the data byte.

The block runs entirely in the system clock domain. The select, serial clock and data-in pins pass through a synchronizer and are edge-detected, so the serial clock is oversampled rather than used as a clock. Each half-period of the serial clock must last at least `SYNC_STAGES + 2` system clocks.

A write reaches the register bus only after select returns high. It then appears as a one-cycle strobe carrying the address and data. On a read, the address is presented on the read port as soon as the sixteenth bit is in. The returned byte is then shifted out on data-out over the last eight bit times, and it changes after each serial-clock falling edge. Any window that does not hold exactly 24 bits is dropped, as is any frame whose multi-byte field is nonzero. Both cases are flagged.

Top module: `sreg_link`

## Requirements
- R1: A write frame puts its address and data byte on `wr_addr` and `wr_data`, which are valid while `wr_en` is high. The frame is bit 23 = 0 (direction), bits 22:21 = 00 (multi-byte), bits 20:8 = address and bits 7:0 = data, shifted in MSB first on rising serial-clock edges.
- R2: `wr_en` rises exactly `SYNC_STAGES + 1` system clocks after `cs_n` rises, and never while `cs_n` is low.
- R3: `wr_en` is high for exactly one system clock per accepted write frame.
- R4: In a read frame (bit 23 = 1), `rd_addr` holds the 13-bit address once 16 bits are in. The byte on `rd_data` is then driven on `sdo` MSB first, one bit per bit time over bits 16..23. Each bit is updated after the serial-clock falling edge that precedes its bit time.
- R5: A read frame produces no `wr_en` pulse.
- R6: A frame whose multi-byte field (bits 22:21) is nonzero produces no write and no `sdo_oe`. It raises a one-cycle `frame_err` pulse `SYNC_STAGES + 1` clocks after `cs_n` rises.
- R7: If `cs_n` rises after any bit count other than 24, the frame produces no write and raises a one-cycle `frame_err` pulse `SYNC_STAGES + 1` clocks after `cs_n` rises.
- R8: `sdo_oe` is low throughout write frames and during the header of read frames. It is high during the data phase of a read and returns low once `cs_n` is high.
- R9: While `rst` is high and right after it falls, `wr_en`, `frame_err`, `sdo` and `sdo_oe` are 0.
- R10: Serial-clock edges while `cs_n` is high are not counted, so a frame that follows them is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial read data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| rd_addr | output | ADDR_W | Address presented to the register file for reads |
| rd_data | input | DATA_W | Byte returned by the register file for `rd_addr` |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Write address, valid with `wr_en` |
| wr_data | output | DATA_W | Write data, valid with `wr_en` |
| frame_err | output | 1 | One-cycle pulse for a rejected frame |

## Verification
The hardest case to reach is the read hand-off. The address is latched after the sixteenth rising edge and the register file answers combinationally. The first data bit must then be on `sdo` after the following falling edge, well before the seventeenth rising edge. The bench reaches this case by running whole read frames at a slow, fixed serial-clock half-period. It samples `sdo` and `sdo_oe` just before each rising edge of the data phase and compares them with a byte it computes from the address it sent. It also replays windows that end one bit early or one bit late. Those windows leave the shift register full of plausible-looking data, so it is the bit count alone that must cause the rejection.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int DIR_W = 1;
  localparam int MB_W  = 2;

  typedef enum logic [1:0] {
    VERD_IDLE,
    VERD_WRITE,
    VERD_READ,
    VERD_REJECT
  } verdict_e;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int              N_SIG   = 3,
  parameter int              STAGES  = 2,
  parameter logic [N_SIG-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SIG-1:0] din,
  output logic [N_SIG-1:0] lvl,
  output logic [N_SIG-1:0] rise,
  output logic [N_SIG-1:0] fall
);

  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    logic [STAGES-1:0] chain;
    logic              prev;

    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL[g];
        else     chain <= din[g];
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], din[g]};
      end
    end

    always_ff @(posedge clk) begin
      if (rst) prev <= RST_VAL[g];
      else     prev <= chain[STAGES-1];
    end

    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~prev;
    assign fall[g] = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/sreg_deser.sv
module sreg_deser
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  localparam int HDR_W   = DIR_W + MB_W + ADDR_W,
  localparam int FRAME_W = HDR_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic [CNT_W-1:0]  cnt,
  output logic              hdr_dir,
  output logic [MB_W-1:0]   hdr_mb,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic [DATA_W-1:0] data_q
);

  localparam logic [CNT_W-1:0] CNT_MAX      = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_W - 1);

  logic [FRAME_W-1:0] sh;
  logic [HDR_W-1:0]   hdr;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sh  <= '0;
      cnt <= '0;
      hdr <= '0;
    end else if (bit_stb) begin
      sh <= {sh[FRAME_W-2:0], bit_in};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (cnt == CNT_HDR_LAST) hdr <= {sh[HDR_W-2:0], bit_in};
    end
  end

  assign hdr_dir  = hdr[HDR_W-1];
  assign hdr_mb   = hdr[HDR_W-2 -: MB_W];
  assign hdr_addr = hdr[ADDR_W-1:0];
  assign data_q   = sh[DATA_W-1:0];

  a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && active) |=> (cnt == CNT_MAX || cnt == '0));

  a_r10_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0));

  a_r4_hdr_held: assert property (@(posedge clk) disable iff (rst)
    (active && !(bit_stb && cnt == CNT_HDR_LAST)) |=> $stable(hdr));

endmodule

// File: rtl/sreg_readout.sv
module sreg_readout #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  parameter int HDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              fall_stb,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hdr_dir,
  input  logic              hdr_mb_zero,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdo,
  output logic              sdo_oe
);

  logic [DATA_W-1:0] sh;
  logic              oe_q;
  logic              load;

  assign load = fall_stb && hdr_dir && hdr_mb_zero && (cnt == CNT_W'(HDR_W));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sh   <= '0;
      oe_q <= 1'b0;
    end else if (load) begin
      sh   <= rd_data;
      oe_q <= 1'b1;
    end else if (fall_stb && oe_q) begin
      sh <= {sh[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo    = sh[DATA_W-1];
  assign sdo_oe = oe_q;

  a_r8_oe_off_idle: assert property (@(posedge clk) disable iff (rst)
    !active |=> !sdo_oe);

  a_r4_sdo_hold: assert property (@(posedge clk) disable iff (rst)
    (active && !fall_stb) |=> $stable(sdo));

  a_r8_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(hdr_dir && hdr_mb_zero));

endmodule

// File: rtl/sreg_commit.sv
module sreg_commit
  import sreg_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 5,
  parameter int FRAME_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_rise,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hdr_dir,
  input  logic [MB_W-1:0]   hdr_mb,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_err
);

  verdict_e verdict;

  always_comb begin
    verdict = VERD_IDLE;
    if (cs_rise) begin
      if (cnt != CNT_W'(FRAME_W) || hdr_mb != '0) verdict = VERD_REJECT;
      else if (hdr_dir)                          verdict = VERD_READ;
      else                                       verdict = VERD_WRITE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      frame_err <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en     <= (verdict == VERD_WRITE);
      frame_err <= (verdict == VERD_REJECT);
      if (verdict == VERD_WRITE) begin
        wr_addr <= hdr_addr;
        wr_data <= data;
      end
    end
  end

  a_r3_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  a_r2_wr_after_cs: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(cs_rise));

  a_r7_err_after_cs: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> $past(cs_rise));

  a_r6_err_excludes_wr: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && frame_err));

  a_r5_read_no_write: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && hdr_dir) |=> !wr_en);

endmodule

// File: rtl/sreg_link.sv
module sreg_link
  import sreg_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_err
);

  localparam int HDR_W   = DIR_W + MB_W + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  localparam int IDX_CS   = 2;
  localparam int IDX_SCLK = 1;
  localparam int IDX_SDI  = 0;

  logic [2:0] pin_lvl, pin_rise, pin_fall;

  sreg_sync #(
    .N_SIG   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({cs_n, sclk, sdi}),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  logic active, bit_stb, fall_stb, cs_rise;

  assign active   = ~pin_lvl[IDX_CS];
  assign bit_stb  = pin_rise[IDX_SCLK] & active;
  assign fall_stb = pin_fall[IDX_SCLK] & active;
  assign cs_rise  = pin_rise[IDX_CS];

  logic [CNT_W-1:0]  cnt;
  logic              hdr_dir;
  logic [MB_W-1:0]   hdr_mb;
  logic [ADDR_W-1:0] hdr_addr;
  logic [DATA_W-1:0] data_q;

  sreg_deser #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_deser (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .bit_stb  (bit_stb),
    .bit_in   (pin_lvl[IDX_SDI]),
    .cnt      (cnt),
    .hdr_dir  (hdr_dir),
    .hdr_mb   (hdr_mb),
    .hdr_addr (hdr_addr),
    .data_q   (data_q)
  );

  assign rd_addr = hdr_addr;

  sreg_readout #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .HDR_W  (HDR_W)
  ) u_readout (
    .clk         (clk),
    .rst         (rst),
    .active      (active),
    .fall_stb    (fall_stb),
    .cnt         (cnt),
    .hdr_dir     (hdr_dir),
    .hdr_mb_zero (hdr_mb == '0),
    .rd_data     (rd_data),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe)
  );

  sreg_commit #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .FRAME_W (FRAME_W)
  ) u_commit (
    .clk       (clk),
    .rst       (rst),
    .cs_rise   (cs_rise),
    .cnt       (cnt),
    .hdr_dir   (hdr_dir),
    .hdr_mb    (hdr_mb),
    .hdr_addr  (hdr_addr),
    .data      (data_q),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .frame_err (frame_err)
  );

  a_r2_no_write_in_frame: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> !wr_en);

endmodule

// File: tb/sim_sreg_link.sv
module sim_sreg_link;

  localparam int H   = 5;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe, wr_en, frame_err;
  logic [12:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101} ^ 8'h3C;
  endfunction

  assign rd_data = mem_f(rd_addr);

  sreg_link u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .frame_err(frame_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int at; logic [12:0] a; logic [7:0] d; } wev_t;
  typedef struct { int at; string tag; } eev_t;
  wev_t wq[$];
  eev_t eq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Reference comparison on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ew, ee;
      ew = (wq.size() > 0) && (wq[0].at == cyc);
      ee = (eq.size() > 0) && (eq[0].at == cyc);
      if (wr_en || ew) begin
        chk(wr_en == ew, ew ? "R2" : "R5", "wr_en pulse timing", 32'(wr_en), 32'(ew));
        if (wr_en && ew) begin
          chk(wr_addr == wq[0].a, "R1", "wr_addr", 32'(wr_addr), 32'(wq[0].a));
          chk(wr_data == wq[0].d, "R1", "wr_data", 32'(wr_data), 32'(wq[0].d));
        end
        if (ew) void'(wq.pop_front());
      end
      if (frame_err || ee) begin
        chk(frame_err == ee, ee ? eq[0].tag : "R7", "frame_err pulse", 32'(frame_err), 32'(ee));
        if (ee) void'(eq.pop_front());
      end
    end
  end

  task automatic xfer(input logic [31:0] bits, input int n,
                      output logic [7:0] rx, output bit oe_hdr, output bit oe_dat);
    rx = '0; oe_hdr = 1'b0; oe_dat = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      repeat (H) @(negedge clk);
      if (i < 16) oe_hdr |= sdo_oe;
      else if (i < 24) begin
        rx[23-i] = sdo;
        oe_dat &= sdo_oe;
      end
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
    chk(sdo_oe == 1'b0, "R8", "oe after select high", 32'(sdo_oe), 0);
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] rx; bit oh, od; wev_t w;
    xfer({8'h0, 1'b0, 2'b00, a, d}, 24, rx, oh, od);
    w.at = cyc + LAT; w.a = a; w.d = d;
    wq.push_back(w);
    chk(!oh && !od, "R8", "oe during write", {oh, od}, 0);
    settle();
  endtask

  task automatic do_read(input logic [12:0] a);
    logic [7:0] rx; bit oh, od;
    xfer({8'h0, 1'b1, 2'b00, a, 8'hC3}, 24, rx, oh, od);
    chk(rx == mem_f(a), "R4", "read byte on sdo", 32'(rx), 32'(mem_f(a)));
    chk(!oh && od, "R8", "oe header/data", {oh, od}, 32'b01);
    settle();
  endtask

  task automatic do_bad_mb(input logic dir, input logic [1:0] mb,
                           input logic [12:0] a, input logic [7:0] d);
    logic [7:0] rx; bit oh, od; eev_t e;
    xfer({8'h0, dir, mb, a, d}, 24, rx, oh, od);
    e.at = cyc + LAT; e.tag = "R6";
    eq.push_back(e);
    chk(!oh && !od, "R6", "oe for rejected frame", {oh, od}, 0);
    settle();
  endtask

  task automatic do_bad_len(input logic [31:0] bits, input int n);
    logic [7:0] rx; bit oh, od; eev_t e;
    xfer(bits, n, rx, oh, od);
    e.at = cyc + LAT; e.tag = "R7";
    eq.push_back(e);
    settle();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=timeout exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: during reset
    chk({wr_en, frame_err, sdo, sdo_oe} == 4'b0, "R9", "outputs in reset",
        {wr_en, frame_err, sdo, sdo_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({wr_en, frame_err, sdo, sdo_oe} == 4'b0, "R9", "outputs after reset",
        {wr_en, frame_err, sdo, sdo_oe}, 0);

    // R1 R2 R3: writes with varied patterns
    do_write(13'h0000, 8'h11);
    do_write(13'h1FFF, 8'hEE);
    do_write(13'h0A5A, 8'h3C);
    do_write(13'h1555, 8'h80);

    // R4 R5: reads
    do_read(13'h0A5A);
    do_read(13'h1FFF);
    do_read(13'h0000);
    do_read(13'h1234);

    // R6: multi-byte field nonzero
    do_bad_mb(1'b0, 2'b01, 13'h0100, 8'h55);
    do_bad_mb(1'b0, 2'b10, 13'h0101, 8'hAA);
    do_bad_mb(1'b1, 2'b11, 13'h0102, 8'h00);

    // R7: wrong lengths
    do_bad_len({9'h0, 23'h12_3456}, 23);
    do_bad_len({7'h0, 25'h0_ABCD_E}, 25);
    do_bad_len({24'h0, 8'hFF}, 8);
    do_write(13'h0042, 8'h99);

    // R10: serial clock toggles while deselected
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) begin sclk = 1'b1; sdi = 1'b1; end
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    sdi = 1'b0;
    do_write(13'h0777, 8'h5B);
    do_read(13'h0777);

    repeat (20) @(negedge clk);
    chk(wq.size() == 0, "R2", "pending writes", wq.size(), 0);
    chk(eq.size() == 0, "R7", "pending errors", eq.size(), 0);
    finish_run();
  end

endmodule